// File: doc/BRIEF.md
# Bus Initiator Lock Sequencer

This block sits beside the master engine of a parallel-bus initiator. It drives the active-low exclusive-access signal for a sequence of transactions to one target. The requester gives it three commands: open a locked sequence, continue it with another transaction, or finish it. The block watches the bus-side frame, initiator-ready, target-ready and stop lines, plus master-abort and target-abort indications from the master engine. From these it decides, cycle by cycle, whether the lock line is driven asserted or negated.

The lock line is held negated in every address phase of the sequence and asserted from the next cycle on. The lock only counts as won once the first data phase of the opening read has completed, which means initiator-ready and target-ready are both low in the same cycle. After that the line stays asserted between transactions. It is released when the requester finishes, when an abort ends the sequence early, or when the opening read is retried before any data moved. One-cycle pulses report the outcome to the requester: won, lost, released or command rejected. A level output shows that the lock is held.

The requester must issue an open or continue command in the cycle just before the master engine starts the address phase. An address phase is the first cycle in which frame is seen low after a cycle in which it was high.

Top module: `lock_seq_top`

## Requirements
- R1: Under synchronous reset `lock_n` is 1 and `lock_held`, `lock_established`, `lock_lost`, `lock_released` and `cmd_reject` are all 0.
- R2: After an accepted open command (`cmd_op` = 0, `cmd_rd` = 1), `lock_n` stays 1 up to and including the address phase, and becomes 0 in the cycle right after the address phase.
- R3: An open command with `cmd_rd` = 0 (a write) is rejected: `cmd_reject` is 1 in the next cycle and `lock_n` stays 1.
- R4: The first cycle of the opening transaction with `irdy_n` = 0 and `trdy_n` = 0 is followed by one cycle of `lock_established` = 1, and `lock_held` becomes 1.
- R5: If the opening transaction sees `stop_n` = 0 with `trdy_n` = 1 before any data phase completes, the next cycle has `lock_lost` = 1, `lock_n` = 1 and `lock_held` = 0.
- R6: `master_abort` or `target_abort` during any transaction of the sequence is followed by `lock_lost` = 1, `lock_n` = 1 and `lock_held` = 0 in the next cycle. An abort takes precedence over a data phase or a final phase in the same cycle.
- R7: Once the lock is established and a transaction ends without a finish request, `lock_n` stays 0 while the bus is idle.
- R8: A continue command (`cmd_op` = 1) while the lock is held and idle sets `lock_n` to 1 in the next cycle. It stays 1 through the address phase and becomes 0 the cycle after.
- R9: With a finish request (`cmd_op` = 2) pending or given in the same cycle, the final data phase (`frame_n` = 1, `irdy_n` = 0, `trdy_n` = 0 or `stop_n` = 0) is followed by `lock_n` = 1 and `lock_released` = 1 in the cycle where `irdy_n` returns high. This also covers establishment and release in the same cycle.
- R10: A finish command while the lock is held with no transaction running is followed by `lock_n` = 1 and `lock_released` = 1 in the next cycle.
- R11: For `REL_GAP` cycles after a release, every command is rejected; after that an open read is accepted.
- R12: A command that is illegal for the current state, such as continue while unlocked or the reserved op code 3, is rejected with `cmd_reject` = 1 and leaves `lock_n` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 open, 1 continue, 2 finish, 3 reserved |
| cmd_rd | input | 1 | 1 when the opening transaction is a read |
| frame_n | input | 1 | Bus frame, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| stop_n | input | 1 | Target stop (retry or disconnect), active low |
| master_abort | input | 1 | Master-abort indication from the master engine |
| target_abort | input | 1 | Target-abort indication from the master engine |
| lock_n | output | 1 | Registered exclusive-access line, active low |
| lock_held | output | 1 | Lock established and not yet given up |
| lock_established | output | 1 | One-cycle pulse: lock won |
| lock_lost | output | 1 | One-cycle pulse: abort or retry of the opening read |
| lock_released | output | 1 | One-cycle pulse: sequence finished normally |
| cmd_reject | output | 1 | One-cycle pulse: command refused |

## Verification
The opening read can win the lock and end the whole sequence in one cycle. This happens when a finish request is pending, or arrives, in the same cycle as a single-phase opening read. The bench provokes it with a directed case and expects `lock_established` and `lock_released` high together, with `lock_n` already back to 1. Random traffic also lets an abort coincide with a data or final phase. There the expected outcome is a lost lock and no won or released pulse, judged by a cycle-level model kept in the bench.

// File: rtl/lock_seq_pkg.sv
package lock_seq_pkg;

    localparam int OP_W = 2;

    typedef enum logic [OP_W-1:0] {
        OP_OPEN   = 2'd0,
        OP_CONT   = 2'd1,
        OP_FINISH = 2'd2,
        OP_RSVD   = 2'd3
    } lk_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN_ADDR,
        ST_OPEN_WAIT,
        ST_LOCKED_IDLE,
        ST_CONT_ADDR,
        ST_LOCKED_XFER,
        ST_RELEASE
    } lk_state_e;

    // Decoded bus conditions for one cycle
    typedef struct packed {
        logic addr_phase;
        logic data_xfer;
        logic retry;
        logic last_phase;
        logic abort;
    } bus_evt_t;

    // Requester-facing pulses
    typedef struct packed {
        logic est;
        logic lost;
        logic rel;
        logic rej;
    } lk_pulse_t;

    // States in which the lock line is driven asserted
    function automatic logic drives_lock(lk_state_e s);
        return (s == ST_OPEN_WAIT) || (s == ST_LOCKED_IDLE) || (s == ST_LOCKED_XFER);
    endfunction

    // States in which the lock is owned by this initiator
    function automatic logic owns_lock(lk_state_e s);
        return (s == ST_LOCKED_IDLE) || (s == ST_CONT_ADDR) || (s == ST_LOCKED_XFER);
    endfunction

    // States with a transaction in flight, where an abort ends the sequence
    function automatic logic in_transaction(lk_state_e s);
        return (s == ST_OPEN_ADDR) || (s == ST_OPEN_WAIT) ||
               (s == ST_CONT_ADDR) || (s == ST_LOCKED_XFER);
    endfunction

endpackage

// File: rtl/lock_seq_bus_mon.sv
module lock_seq_bus_mon
    import lock_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     frame_n,
    input  logic     irdy_n,
    input  logic     trdy_n,
    input  logic     stop_n,
    input  logic     master_abort,
    input  logic     target_abort,
    output bus_evt_t evt
);

    logic frame_n_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_n_q <= 1'b1;
        end else begin
            frame_n_q <= frame_n;
        end
    end

    always_comb begin
        evt.addr_phase = !frame_n && frame_n_q;
        evt.data_xfer  = !irdy_n && !trdy_n;
        evt.retry      = !stop_n && trdy_n;
        evt.last_phase = frame_n && !irdy_n && (!trdy_n || !stop_n);
        evt.abort      = master_abort || target_abort;
    end

endmodule

// File: rtl/lock_seq_fsm.sv
module lock_seq_fsm
    import lock_seq_pkg::*;
#(
    parameter int REL_GAP = 1
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      cmd_valid,
    input  lk_op_e    cmd_op,
    input  logic      cmd_rd,
    input  bus_evt_t  evt,
    output lk_state_e st,
    output logic      fin_pend,
    output lk_state_e st_nxt,
    output lk_pulse_t pulse_nxt
);

    localparam int GAP_W = (REL_GAP > 1) ? $clog2(REL_GAP) : 1;

    logic gap_done;
    logic pend_nxt;
    logic fin_req;
    logic pend_eff;

    assign fin_req  = cmd_valid && (cmd_op == OP_FINISH);
    assign pend_eff = fin_pend || fin_req;

    generate
        if (REL_GAP > 1) begin : g_gap
            logic [GAP_W-1:0] gap_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    gap_q <= '0;
                end else if (st_nxt == ST_RELEASE && st != ST_RELEASE) begin
                    gap_q <= GAP_W'(REL_GAP - 1);
                end else if (st == ST_RELEASE && gap_q != '0) begin
                    gap_q <= gap_q - 1'b1;
                end
            end
            assign gap_done = (gap_q == '0);
        end else begin : g_nogap
            assign gap_done = 1'b1;
        end
    endgenerate

    always_comb begin
        st_nxt    = st;
        pend_nxt  = fin_pend;
        pulse_nxt = '0;
        unique case (st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    if (cmd_op == OP_OPEN && cmd_rd) st_nxt = ST_OPEN_ADDR;
                    else                             pulse_nxt.rej = 1'b1;
                end
            end
            ST_OPEN_ADDR: begin
                if (cmd_valid) pulse_nxt.rej = 1'b1;
                if (evt.abort) begin
                    st_nxt         = ST_IDLE;
                    pulse_nxt.lost = 1'b1;
                end else if (evt.addr_phase) begin
                    st_nxt = ST_OPEN_WAIT;
                end
            end
            ST_OPEN_WAIT: begin
                if (cmd_valid && !fin_req) pulse_nxt.rej = 1'b1;
                if (fin_req) pend_nxt = 1'b1;
                if (evt.abort) begin
                    st_nxt         = ST_IDLE;
                    pulse_nxt.lost = 1'b1;
                end else if (evt.data_xfer) begin
                    pulse_nxt.est = 1'b1;
                    if (evt.last_phase) begin
                        if (pend_eff) begin
                            st_nxt        = ST_RELEASE;
                            pulse_nxt.rel = 1'b1;
                        end else begin
                            st_nxt = ST_LOCKED_IDLE;
                        end
                    end else begin
                        st_nxt = ST_LOCKED_XFER;
                    end
                end else if (evt.retry) begin
                    st_nxt         = ST_IDLE;
                    pulse_nxt.lost = 1'b1;
                end
            end
            ST_LOCKED_IDLE: begin
                if (cmd_valid) begin
                    if (cmd_op == OP_CONT) begin
                        st_nxt = ST_CONT_ADDR;
                    end else if (cmd_op == OP_FINISH) begin
                        st_nxt        = ST_RELEASE;
                        pulse_nxt.rel = 1'b1;
                    end else begin
                        pulse_nxt.rej = 1'b1;
                    end
                end
            end
            ST_CONT_ADDR: begin
                if (cmd_valid && !fin_req) pulse_nxt.rej = 1'b1;
                if (fin_req) pend_nxt = 1'b1;
                if (evt.abort) begin
                    st_nxt         = ST_IDLE;
                    pulse_nxt.lost = 1'b1;
                end else if (evt.addr_phase) begin
                    st_nxt = ST_LOCKED_XFER;
                end
            end
            ST_LOCKED_XFER: begin
                if (cmd_valid && !fin_req) pulse_nxt.rej = 1'b1;
                if (fin_req) pend_nxt = 1'b1;
                if (evt.abort) begin
                    st_nxt         = ST_IDLE;
                    pulse_nxt.lost = 1'b1;
                end else if (evt.last_phase) begin
                    if (pend_eff) begin
                        st_nxt        = ST_RELEASE;
                        pulse_nxt.rel = 1'b1;
                    end else begin
                        st_nxt = ST_LOCKED_IDLE;
                    end
                end
            end
            ST_RELEASE: begin
                if (cmd_valid) pulse_nxt.rej = 1'b1;
                if (gap_done) st_nxt = ST_IDLE;
            end
            default: begin
                st_nxt = ST_IDLE;
            end
        endcase
        if (!(st_nxt == ST_OPEN_WAIT || st_nxt == ST_CONT_ADDR || st_nxt == ST_LOCKED_XFER)) begin
            pend_nxt = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            fin_pend <= 1'b0;
        end else begin
            st       <= st_nxt;
            fin_pend <= pend_nxt;
        end
    end

endmodule

// File: rtl/lock_seq_drive.sv
module lock_seq_drive
    import lock_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  lk_state_e st_nxt,
    input  lk_pulse_t pulse_nxt,
    output logic      lock_n,
    output logic      lock_held,
    output lk_pulse_t pulse
);

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_n    <= 1'b1;
            lock_held <= 1'b0;
            pulse     <= '0;
        end else begin
            lock_n    <= !drives_lock(st_nxt);
            lock_held <= owns_lock(st_nxt);
            pulse     <= pulse_nxt;
        end
    end

endmodule

// File: rtl/lock_seq_top.sv
module lock_seq_top
    import lock_seq_pkg::*;
#(
    parameter int REL_GAP = 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_valid,
    input  logic [OP_W-1:0] cmd_op,
    input  logic            cmd_rd,
    input  logic            frame_n,
    input  logic            irdy_n,
    input  logic            trdy_n,
    input  logic            stop_n,
    input  logic            master_abort,
    input  logic            target_abort,
    output logic            lock_n,
    output logic            lock_held,
    output logic            lock_established,
    output logic            lock_lost,
    output logic            lock_released,
    output logic            cmd_reject
);

    bus_evt_t  evt;
    lk_state_e st;
    lk_state_e st_nxt;
    lk_pulse_t pulse_nxt;
    lk_pulse_t pulse;
    logic      fin_pend;

    lock_seq_bus_mon u_mon (
        .clk          (clk),
        .rst          (rst),
        .frame_n      (frame_n),
        .irdy_n       (irdy_n),
        .trdy_n       (trdy_n),
        .stop_n       (stop_n),
        .master_abort (master_abort),
        .target_abort (target_abort),
        .evt          (evt)
    );

    lock_seq_fsm #(.REL_GAP(REL_GAP)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (lk_op_e'(cmd_op)),
        .cmd_rd    (cmd_rd),
        .evt       (evt),
        .st        (st),
        .fin_pend  (fin_pend),
        .st_nxt    (st_nxt),
        .pulse_nxt (pulse_nxt)
    );

    lock_seq_drive u_drv (
        .clk       (clk),
        .rst       (rst),
        .st_nxt    (st_nxt),
        .pulse_nxt (pulse_nxt),
        .lock_n    (lock_n),
        .lock_held (lock_held),
        .pulse     (pulse)
    );

    assign lock_established = pulse.est;
    assign lock_lost        = pulse.lost;
    assign lock_released    = pulse.rel;
    assign cmd_reject       = pulse.rej;

endmodule

// File: rtl/lock_seq_chk.sv
module lock_seq_chk
    import lock_seq_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            cmd_valid,
    input logic [OP_W-1:0] cmd_op,
    input logic            cmd_rd,
    input bus_evt_t        evt,
    input lk_state_e       st,
    input logic            fin_pend,
    input logic            lock_n,
    input logic            lock_held,
    input logic            lock_established,
    input logic            lock_lost,
    input logic            lock_released,
    input logic            cmd_reject
);

    // R2
    addr_negated_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_OPEN_ADDR || st == ST_CONT_ADDR) |-> lock_n);

    // R2
    lock_after_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_OPEN_ADDR && evt.addr_phase && !evt.abort) |=> !lock_n);

    // R3
    write_open_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && cmd_valid && cmd_op == 2'd0 && !cmd_rd) |=> (cmd_reject && lock_n));

    // R4
    established_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_OPEN_WAIT && evt.data_xfer && !evt.abort) |=> (lock_established && !lock_lost));

    // R6
    abort_release_chk: assert property (@(posedge clk) disable iff (rst)
        (evt.abort && in_transaction(st)) |=> (lock_n && lock_lost && !lock_held));

    // R7
    hold_between_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_LOCKED_IDLE && !cmd_valid) |=> !lock_n);

    // R9
    finish_release_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_LOCKED_XFER && fin_pend && evt.last_phase && !evt.abort) |=> (lock_n && lock_released));

    // R11
    gap_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RELEASE && cmd_valid) |=> cmd_reject);

    // R6
    pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(lock_lost && (lock_established || lock_released)));

endmodule

bind lock_seq_top lock_seq_chk u_chk (
    .clk              (clk),
    .rst              (rst),
    .cmd_valid        (cmd_valid),
    .cmd_op           (cmd_op),
    .cmd_rd           (cmd_rd),
    .evt              (evt),
    .st               (st),
    .fin_pend         (fin_pend),
    .lock_n           (lock_n),
    .lock_held        (lock_held),
    .lock_established (lock_established),
    .lock_lost        (lock_lost),
    .lock_released    (lock_released),
    .cmd_reject       (cmd_reject)
);

// File: tb/tb_lock_seq_top.sv
`timescale 1ns/1ps
module tb_lock_seq_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic       cmd_rd = 1'b0;
    logic       frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1, stop_n = 1'b1;
    logic       master_abort = 1'b0, target_abort = 1'b0;
    logic       lock_n, lock_held, lock_established, lock_lost, lock_released, cmd_reject;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    lock_seq_top dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_rd(cmd_rd),
        .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n), .stop_n(stop_n),
        .master_abort(master_abort), .target_abort(target_abort),
        .lock_n(lock_n), .lock_held(lock_held), .lock_established(lock_established),
        .lock_lost(lock_lost), .lock_released(lock_released), .cmd_reject(cmd_reject)
    );

    // Bench model: 0 idle, 1 open addr, 2 open wait, 3 held idle, 4 cont addr, 5 held xfer, 6 release
    int m_st = 0;
    bit m_pend = 0, m_fq = 1;
    bit m_lock_n = 1, m_held = 0, m_est = 0, m_lost = 0, m_rel = 0, m_rej = 0;

    task automatic model_edge();
        bit ap, dx, rt, lp, ab, fin, pe;
        int ns;
        bit np;
        ap = !frame_n && m_fq;
        dx = !irdy_n && !trdy_n;
        rt = !stop_n && trdy_n;
        lp = frame_n && !irdy_n && (!trdy_n || !stop_n);
        ab = master_abort || target_abort;
        fin = cmd_valid && cmd_op == 2'd2;
        pe = m_pend || fin;
        ns = m_st; np = m_pend;
        m_est = 0; m_lost = 0; m_rel = 0; m_rej = 0;
        if (rst) begin
            m_st = 0; m_pend = 0; m_fq = 1; m_lock_n = 1; m_held = 0;
            return;
        end
        case (m_st)
            0: if (cmd_valid) begin
                   if (cmd_op == 2'd0 && cmd_rd) ns = 1; else m_rej = 1;
               end
            1: begin
                   if (cmd_valid) m_rej = 1;
                   if (ab) begin ns = 0; m_lost = 1; end
                   else if (ap) ns = 2;
               end
            2, 4, 5: begin
                   if (cmd_valid && !fin) m_rej = 1;
                   if (fin) np = 1;
                   if (ab) begin ns = 0; m_lost = 1; end
                   else if (m_st == 4) begin
                       if (ap) ns = 5;
                   end else if (m_st == 2 && dx) begin
                       m_est = 1;
                       if (lp) begin
                           if (pe) begin ns = 6; m_rel = 1; end else ns = 3;
                       end else ns = 5;
                   end else if (m_st == 2 && rt) begin
                       ns = 0; m_lost = 1;
                   end else if (m_st == 5 && lp) begin
                       if (pe) begin ns = 6; m_rel = 1; end else ns = 3;
                   end
               end
            3: if (cmd_valid) begin
                   if (cmd_op == 2'd1) ns = 4;
                   else if (cmd_op == 2'd2) begin ns = 6; m_rel = 1; end
                   else m_rej = 1;
               end
            default: begin
                   if (cmd_valid) m_rej = 1;
                   ns = 0;
               end
        endcase
        if (!(ns == 2 || ns == 4 || ns == 5)) np = 0;
        m_st = ns; m_pend = np; m_fq = frame_n;
        m_lock_n = !(ns == 2 || ns == 3 || ns == 5);
        m_held = (ns == 3 || ns == 4 || ns == 5);
    endtask

    task automatic tick();
        model_edge();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic bus(logic f, logic i, logic t, logic s);
        frame_n = f; irdy_n = i; trdy_n = t; stop_n = s;
    endtask

    task automatic cmd(logic v, logic [1:0] op, logic rd);
        cmd_valid = v; cmd_op = op; cmd_rd = rd;
    endtask

    task automatic cmp_model();
        string tag;
        if (m_lost) tag = "R6";
        else if (m_est) tag = "R4";
        else if (m_rel) tag = "R9";
        else if (m_rej) tag = "R12";
        else tag = "R7";
        chk(tag, "lock_n", lock_n, m_lock_n);
        chk(tag, "lock_held", lock_held, m_held);
        chk(tag, "established", lock_established, m_est);
        chk(tag, "lost", lock_lost, m_lost);
        chk(tag, "released", lock_released, m_rel);
        chk(tag, "reject", cmd_reject, m_rej);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) tick();
        // R1 reset state
        chk("R1", "lock_n", lock_n, 1'b1);
        chk("R1", "lock_held", lock_held, 1'b0);
        chk("R1", "pulses", lock_established | lock_lost | lock_released | cmd_reject, 1'b0);
        rst = 1'b0;
        tick();

        // R3 open with a write is refused
        cmd(1, 2'd0, 0); tick();
        chk("R3", "reject", cmd_reject, 1'b1);
        chk("R3", "lock_n", lock_n, 1'b1);
        cmd(0, 2'd0, 0); tick();
        chk("R3", "reject clears", cmd_reject, 1'b0);

        // R12 continue while unlocked, reserved op
        cmd(1, 2'd1, 1); tick();
        chk("R12", "reject cont", cmd_reject, 1'b1);
        cmd(1, 2'd3, 1); tick();
        chk("R12", "reject rsvd", cmd_reject, 1'b1);
        chk("R12", "lock_n", lock_n, 1'b1);
        cmd(0, 2'd0, 0);

        // R2, R4, R7: opening read with one wait cycle, two data phases
        cmd(1, 2'd0, 1); tick();
        cmd(0, 2'd0, 0); bus(0, 1, 1, 1);
        chk("R2", "lock_n in addr phase", lock_n, 1'b1);
        tick();
        chk("R2", "lock_n after addr phase", lock_n, 1'b0);
        bus(0, 0, 1, 1); tick();
        chk("R4", "no early established", lock_established, 1'b0);
        bus(0, 0, 0, 1); tick();
        chk("R4", "established", lock_established, 1'b1);
        chk("R4", "held", lock_held, 1'b1);
        bus(1, 0, 0, 1); tick();
        chk("R7", "lock_n through final", lock_n, 1'b0);
        chk("R4", "pulse one cycle", lock_established, 1'b0);
        bus(1, 1, 1, 1);
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R7", "lock_n idle", lock_n, 1'b0);
            chk("R7", "held idle", lock_held, 1'b1);
        end

        // R8 continue, then R9 finish on final phase
        cmd(1, 2'd1, 0); tick();
        chk("R8", "lock_n negated before addr", lock_n, 1'b1);
        chk("R8", "still held", lock_held, 1'b1);
        cmd(0, 2'd0, 0); bus(0, 1, 1, 1); tick();
        chk("R8", "lock_n after addr", lock_n, 1'b0);
        cmd(1, 2'd2, 0); bus(1, 0, 0, 1); tick();
        chk("R9", "lock_n released", lock_n, 1'b1);
        chk("R9", "released", lock_released, 1'b1);
        chk("R9", "held drops", lock_held, 1'b0);

        // R11 command in the gap is refused, then accepted
        cmd(1, 2'd0, 1); bus(1, 1, 1, 1); tick();
        chk("R11", "gap reject", cmd_reject, 1'b1);
        chk("R9", "release pulse one cycle", lock_released, 1'b0);
        tick();
        chk("R11", "open accepted", cmd_reject, 1'b0);

        // R5 retry of the opening read
        cmd(0, 2'd0, 0); bus(0, 1, 1, 1); tick();
        chk("R5", "lock_n asserted", lock_n, 1'b0);
        bus(1, 0, 1, 0); tick();
        chk("R5", "lost", lock_lost, 1'b1);
        chk("R5", "lock_n", lock_n, 1'b1);
        chk("R5", "held", lock_held, 1'b0);
        bus(1, 1, 1, 1); tick();
        chk("R5", "lost one cycle", lock_lost, 1'b0);

        // R10 finish while held and idle
        cmd(1, 2'd0, 1); tick();
        cmd(0, 2'd0, 0); bus(0, 1, 1, 1); tick();
        bus(1, 0, 0, 1); tick();
        chk("R4", "single-phase established", lock_established, 1'b1);
        bus(1, 1, 1, 1); tick();
        chk("R7", "held idle", lock_n, 1'b0);
        cmd(1, 2'd2, 0); tick();
        chk("R10", "released", lock_released, 1'b1);
        chk("R10", "lock_n", lock_n, 1'b1);
        cmd(0, 2'd0, 0); tick();

        // R6 abort during a locked transfer, same cycle as a data phase
        cmd(1, 2'd0, 1); tick();
        cmd(0, 2'd0, 0); bus(0, 1, 1, 1); tick();
        bus(0, 0, 0, 1); tick();
        chk("R4", "established", lock_established, 1'b1);
        bus(1, 0, 0, 1); master_abort = 1'b1; tick();
        chk("R6", "lost", lock_lost, 1'b1);
        chk("R6", "lock_n", lock_n, 1'b1);
        chk("R6", "held", lock_held, 1'b0);
        chk("R6", "no release on abort", lock_released, 1'b0);
        master_abort = 1'b0; bus(1, 1, 1, 1); tick();

        // R9 establishment and release in one cycle
        cmd(1, 2'd0, 1); tick();
        cmd(0, 2'd0, 0); bus(0, 1, 1, 1); tick();
        cmd(1, 2'd2, 0); bus(1, 0, 0, 1); tick();
        chk("R9", "established same cycle", lock_established, 1'b1);
        chk("R9", "released same cycle", lock_released, 1'b1);
        chk("R9", "lock_n", lock_n, 1'b1);
        cmd(0, 2'd0, 0); bus(1, 1, 1, 1); tick();

        // Random traffic against the bench model
        for (int n = 0; n < 4000; n++) begin
            cmd_valid    = ($urandom % 5) == 0;
            cmd_op       = 2'($urandom % 4);
            cmd_rd       = ($urandom % 4) != 0;
            frame_n      = ($urandom % 3) != 0;
            irdy_n       = ($urandom % 2) != 0;
            trdy_n       = ($urandom % 2) != 0;
            stop_n       = ($urandom % 6) != 0;
            master_abort = ($urandom % 50) == 0;
            target_abort = ($urandom % 60) == 0;
            tick();
            cmp_model();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule